// File: doc/BRIEF.md
# Two-Write Binary Write-Once Codec

This block lets a 2-bit value be stored in three binary cells that can only be set, never cleared, short of an erase, and still accept any two values in a row. On the first write after an erase it picks a codeword with at most one cell set. On the second write it picks the bitwise complement of the matching first-write codeword, which has at least two cells set. As a result, each transition only turns cells on. Three cells carry two bits, a rate of 2/3.

The encoder side takes a request: the new value and the cells' present contents. One clock later it presents the next cell contents, a mask of the cells to program, and a `full` flag. `full` is raised when no legal update exists, and in that case the cells are left as they were. The decoder side is a separate combinational lookup from any cell pattern to its 2-bit value. The encoder runs a two-state machine: `ST_IDLE` waits for a request and `ST_RESP` presents a result. The transitions are named as follows:
- T_ACCEPT goes from `ST_IDLE` to `ST_RESP` when a request arrives.
- T_CHAIN stays in `ST_RESP` when another request arrives in the response cycle.
- T_DRAIN goes from `ST_RESP` back to `ST_IDLE` when no request arrives.
- T_WAIT stays in `ST_IDLE`.

Top module: `wom2_codec`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsp_valid`, `next_cells`, `wr_mask` and `full` are all 0.
- R2: A response never clears a cell: every cell set in the request's `cur_cells` is set in `next_cells`.
- R3: From the erased state 3'b000, a request for value 01, 10 or 11 gives 3'b100, 3'b010 or 3'b001 in that order, with bit 2 as the leftmost cell.
- R4: From a cell pattern with exactly one cell set, a request for a different value gives that value's complement codeword: 00 gives 3'b111, 01 gives 3'b011, 10 gives 3'b101, 11 gives 3'b110.
- R5: When the codeword for the requested value would need a set cell cleared, `full` is 1, `next_cells` equals `cur_cells` and `wr_mask` is 0. Otherwise `full` is 0.
- R6: A request for the value the cells already decode to returns `cur_cells` unchanged, with `wr_mask` 0 and `full` 0.
- R7: `rsp_valid` is 1 exactly in the cycle after each cycle with `req_valid` high. Requests on back-to-back cycles are each answered. Without a request, `next_cells`, `wr_mask` and `full` hold their last values.
- R8: `dec_value` decodes `dec_cells` combinationally. A pattern with zero or one cell set reads through the R3 table (3'b000 is 00). A pattern with two or three cells set reads through the R4 table.
- R9: `wr_mask` has a 1 exactly where `next_cells` differs from the request's `cur_cells`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Encode request strobe |
| req_value | input | 2 | Value to be stored |
| cur_cells | input | 3 | Present cell contents |
| rsp_valid | output | 1 | Response present this cycle |
| next_cells | output | 3 | Cell contents after the update |
| wr_mask | output | 3 | Cells to be programmed |
| full | output | 1 | No legal update; cells unchanged |
| dec_cells | input | 3 | Cell pattern to decode |
| dec_value | output | 2 | Decoded value |

## Verification
Two things can fall in the same cycle: the response to one request is presented while the next request is being captured (transition T_CHAIN). The bench drives requests on consecutive cycles, and its monitor demands that each response matches its own request rather than the one being captured. The decoder port can also be exercised while the encoder is busy, so the decoder checks are run on a separate pattern, and no encode result may be disturbed by them. Full, same-value and third-write-to-all-ones cases are mixed into the back-to-back stream.

// File: rtl/wom2_pkg.sv
package wom2_pkg;
    localparam int VAL_W  = 2;
    localparam int CELL_N = 3;

    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [CELL_N-1:0] cells_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } enc_st_e;

    // First-write codeword: value 0 is the empty pattern, value v sets one cell.
    function automatic cells_t first_gen(input val_t v);
        cells_t c;
        if (v == '0) c = '0;
        else         c = cells_t'(1) << (CELL_N - int'(v));
        return c;
    endfunction

    function automatic int unsigned set_count(input cells_t c);
        int unsigned n;
        n = 0;
        for (int i = 0; i < CELL_N; i++) n += int'(c[i]);
        return n;
    endfunction
endpackage

// File: rtl/wom2_decode.sv
module wom2_decode
    import wom2_pkg::*;
(
    input  cells_t cells,
    output val_t   value
);
    cells_t base;
    logic   upper;

    always_comb begin
        upper = (set_count(cells) >= 2);
        base  = upper ? ~cells : cells;
        value = '0;
        for (int i = 0; i < CELL_N; i++) begin
            if (base[i]) value = val_t'(CELL_N - i);
        end
    end
endmodule

// File: rtl/wom2_plan.sv
module wom2_plan
    import wom2_pkg::*;
(
    input  cells_t cur,
    input  val_t   cur_val,
    input  val_t   want,
    output cells_t nxt,
    output cells_t mask,
    output logic   no_room
);
    cells_t cand;
    logic   same;
    logic   covers;

    always_comb begin
        same    = (want == cur_val);
        cand    = (cur == '0) ? first_gen(want) : ~first_gen(want);
        covers  = ((cand & cur) == cur);
        no_room = 1'b0;
        if (same) begin
            nxt = cur;
        end else if (covers) begin
            nxt = cand;
        end else begin
            nxt     = cur;
            no_room = 1'b1;
        end
        mask = nxt ^ cur;
    end
endmodule

// File: rtl/wom2_codec.sv
module wom2_codec
    import wom2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_value,
    input  logic [2:0] cur_cells,
    output logic       rsp_valid,
    output logic [2:0] next_cells,
    output logic [2:0] wr_mask,
    output logic       full,
    input  logic [2:0] dec_cells,
    output logic [1:0] dec_value
);
    enc_st_e st_q, st_d;
    val_t    cur_val;
    cells_t  plan_nxt, plan_mask;
    logic    plan_full;

    wom2_decode u_dec_enc (.cells(cur_cells), .value(cur_val));
    wom2_decode u_dec_port(.cells(dec_cells), .value(dec_value));

    wom2_plan u_plan (
        .cur    (cur_cells),
        .cur_val(cur_val),
        .want   (req_value),
        .nxt    (plan_nxt),
        .mask   (plan_mask),
        .no_room(plan_full)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_RESP : ST_IDLE;  // T_ACCEPT / T_WAIT
            ST_RESP: st_d = req_valid ? ST_RESP : ST_IDLE;  // T_CHAIN / T_DRAIN
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_cells <= '0;
            wr_mask    <= '0;
            full       <= 1'b0;
        end else if (req_valid) begin
            next_cells <= plan_nxt;
            wr_mask    <= plan_mask;
            full       <= plan_full;
        end
    end

    assign rsp_valid = (st_q == ST_RESP);
endmodule

// File: rtl/wom2_chk.sv
module wom2_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] cur_cells,
    input logic       rsp_valid,
    input logic [2:0] next_cells,
    input logic [2:0] wr_mask,
    input logic       full
);
    a_r2_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((next_cells & $past(cur_cells)) == $past(cur_cells)));

    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && full) |-> (next_cells == $past(cur_cells) && wr_mask == 3'b000));

    a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (wr_mask == (next_cells ^ $past(cur_cells))));
endmodule

bind wom2_codec wom2_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cur_cells (cur_cells),
    .rsp_valid (rsp_valid),
    .next_cells(next_cells),
    .wr_mask   (wr_mask),
    .full      (full)
);

// File: tb/test_wom2_codec.sv
module test_wom2_codec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_value = '0;
    logic [2:0] cur_cells = '0;
    logic       rsp_valid;
    logic [2:0] next_cells, wr_mask;
    logic       full;
    logic [2:0] dec_cells = '0;
    logic [1:0] dec_value;

    typedef struct packed {
        logic [2:0] nxt;
        logic [2:0] mask;
        logic       fl;
    } exp_t;

    exp_t q[$];
    exp_t last = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wom2_codec i_wom2_codec (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_value(req_value),
        .cur_cells(cur_cells), .rsp_valid(rsp_valid), .next_cells(next_cells),
        .wr_mask(wr_mask), .full(full), .dec_cells(dec_cells), .dec_value(dec_value)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: expected next state given per the R3/R4/R5/R6 tables; mask per R9.
    task automatic enc(input logic [2:0] cur, input logic [1:0] v,
                       input logic [2:0] exp_nxt, input logic exp_full);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_value = v;
        cur_cells = cur;
        e.nxt  = exp_nxt;
        e.mask = exp_nxt ^ cur;
        e.fl   = exp_full;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cur_cells = 3'b111;
            req_value = 2'b10;
        end
    endtask

    // Monitor: samples 2 ns after each rising edge (R7 timing, R2..R6, R9 values).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (running) begin
                n_chk++;
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    if (!rsp_valid) begin
                        n_bad++;
                        $display("FAIL R7 rsp_valid act=0 exp=1");
                    end else if (next_cells !== e.nxt || wr_mask !== e.mask || full !== e.fl) begin
                        n_bad++;
                        $display("FAIL R2-R6/R9 act nxt=%b mask=%b full=%b exp nxt=%b mask=%b full=%b",
                                 next_cells, wr_mask, full, e.nxt, e.mask, e.fl);
                    end
                    last = e;
                end else if (rsp_valid) begin
                    n_bad++;
                    $display("FAIL R7 rsp_valid act=1 exp=0");
                end else if (next_cells !== last.nxt || wr_mask !== last.mask || full !== last.fl) begin
                    n_bad++;
                    $display("FAIL R7 hold act nxt=%b mask=%b full=%b exp nxt=%b mask=%b full=%b",
                             next_cells, wr_mask, full, last.nxt, last.mask, last.fl);
                end
            end
        end
    end

    function automatic logic [1:0] ref_dec(input logic [2:0] c);
        case (c)
            3'b000: return 2'b00;
            3'b100: return 2'b01;
            3'b010: return 2'b10;
            3'b001: return 2'b11;
            3'b111: return 2'b00;
            3'b011: return 2'b01;
            3'b101: return 2'b10;
            default: return 2'b11; // 3'b110
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end

    initial begin
        // R1: outputs during reset and the first cycle after it
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (rsp_valid !== 1'b0 || next_cells !== 3'b000 || wr_mask !== 3'b000 || full !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 act v=%b n=%b m=%b f=%b exp all zero", rsp_valid, next_cells, wr_mask, full);
        end
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R6: empty cells already read 00
        enc(3'b000, 2'b00, 3'b000, 1'b0);
        // R3: first writes
        enc(3'b000, 2'b01, 3'b100, 1'b0);
        enc(3'b000, 2'b10, 3'b010, 1'b0);
        enc(3'b000, 2'b11, 3'b001, 1'b0);
        idle(2);
        // R4: second writes, including 01 then 00
        enc(3'b100, 2'b00, 3'b111, 1'b0);
        enc(3'b100, 2'b10, 3'b101, 1'b0);
        enc(3'b100, 2'b11, 3'b110, 1'b0);
        enc(3'b010, 2'b01, 3'b011, 1'b0);
        enc(3'b001, 2'b10, 3'b101, 1'b0);
        enc(3'b010, 2'b00, 3'b111, 1'b0);
        // R6: same value in second generation and first generation
        enc(3'b100, 2'b01, 3'b100, 1'b0);
        enc(3'b101, 2'b10, 3'b101, 1'b0);
        idle(1);
        // R5: no legal update
        enc(3'b011, 2'b10, 3'b011, 1'b1);
        enc(3'b110, 2'b01, 3'b110, 1'b1);
        enc(3'b111, 2'b01, 3'b111, 1'b1);
        idle(3);
        // R2: an extra write that only sets cells is still allowed
        enc(3'b011, 2'b00, 3'b111, 1'b0);
        enc(3'b101, 2'b11, 3'b101, 1'b1);
        idle(3);

        // R8: decoder over every pattern
        for (int c = 0; c < 8; c++) begin
            dec_cells = 3'(c);
            #1;
            n_chk++;
            if (dec_value !== ref_dec(3'(c))) begin
                n_bad++;
                $display("FAIL R8 cells=%b act=%b exp=%b", 3'(c), dec_value, ref_dec(3'(c)));
            end
        end
        idle(2);
        running = 1'b0;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 pending act=%0d exp=0", q.size());
        end
        report();
    end
endmodule